// File: doc/BRIEF.md
# Four-way set-associative page translation cache

This block keeps recently used virtual-page-to-physical-frame pairs so that a repeated access to a page already translated does not walk the page tables again. Both page numbers are 20 bits wide: the 12-bit byte offset inside a 4 KB page is dropped before the block sees the address. A lookup port takes a virtual page number, a valid flag and a write flag. In the same cycle it returns hit or miss, the physical frame number and the stored access attributes: writable, user and dirty.

After a table walk finishes, the walker installs its result through the fill port. A single flush input is pulsed whenever the page-directory base is rewritten. It drops every cached pair in one clock edge. Storage is organised as a parameterised number of sets of four ways each. The set index comes from the low bits of the virtual page number and the tag from the rest. Each set picks its victim with a three-bit tree pseudo-LRU, but only after it has run out of empty ways.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses and the frame and attribute outputs are zero.
- R2: Lookup is combinational. When `lk_valid` is 1 and a valid entry in set `lk_vpn[IDX_W-1:0]` holds tag `lk_vpn[19:IDX_W]`, `lk_hit` is 1 in that same cycle, with that entry's frame on `lk_pfn` and its attributes on `lk_wr`, `lk_usr` and `lk_dty`. In every other case `lk_hit` is 0 and those outputs are 0.
- R3: A fill (`fill_en`=1 with `flush`=0) writes the entry on the next rising clock edge. It is visible to lookups from the following cycle onward.
- R4: A fill whose virtual page is already cached overwrites that entry in place. It evicts no other entry, and a set never holds two entries with the same tag.
- R5: A lookup with `lk_write`=1 that matches an entry whose dirty attribute is 0 is reported as a miss. A read lookup of the same entry hits.
- R6: `flush`=1 invalidates every entry at the next clock edge. A fill in the same cycle is discarded.
- R7: A fill of a new page into a set that has an invalid way uses the lowest-numbered invalid way and evicts nothing.
- R8: Each set keeps tree bits b0, b1 and b2, cleared by reset and by flush. The victim is way b1 when b0=0 and way 2+b2 when b0=1. A hit or fill on way w makes b0 point to the other half: b0=1 for ways 0 and 1, b0=0 for ways 2 and 3. The same touch makes b1=!w[0] (ways 0 and 1) or b2=!w[0] (ways 2 and 3). A full set evicts its victim way.
- R9: Fills and evictions in one set leave the entries of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | The access is a write |
| lk_hit | output | 1 | Translation found and usable |
| lk_pfn | output | 20 | Physical frame number (0 on miss) |
| lk_wr | output | 1 | Page is writable (0 on miss) |
| lk_usr | output | 1 | Page is user-accessible (0 on miss) |
| lk_dty | output | 1 | Page is already dirty (0 on miss) |
| fill_en | input | 1 | Install a walk result |
| fill_vpn | input | 20 | Virtual page number of the result |
| fill_pfn | input | 20 | Physical frame number of the result |
| fill_wr | input | 1 | Writable attribute to store |
| fill_usr | input | 1 | User attribute to store |
| fill_dty | input | 1 | Dirty attribute to store |
| flush | input | 1 | Invalidate all entries (directory base changed) |

## Verification
The bench builds the block with SETS=4. A set then holds every page whose number has the same two low bits, and five fills to one set are enough to force an eviction. That makes the invalid-first choice, the tree victim choice and the in-place refresh observable within a short sequence, with entries in a neighbouring set kept as witnesses for set independence. The sequence is arranged so that the way evicted under the tree rule differs both from what true LRU would evict and from what a victim choice that ignores empty ways would evict.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef struct packed {
    logic wr;
    logic usr;
    logic dty;
  } xlat_attr_t;
endpackage

// File: rtl/xlat_plru.sv
module xlat_plru
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);
  logic [2:0] bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    if (clear) begin
      bits_d = '0;
    end else if (touch_en) begin
      if (!touch_way[1]) begin
        bits_d[0] = 1'b1;
        bits_d[1] = ~touch_way[0];
      end else begin
        bits_d[0] = 1'b0;
        bits_d[2] = ~touch_way[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign victim = bits_q[0] ? {1'b1, bits_q[2]} : {1'b0, bits_q[1]};

  // R8: the way just touched is never the next victim
  a_r8_victim_not_recent: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && !clear) |=> (victim != $past(touch_way)));
endmodule

// File: rtl/xlat_set_match.sv
module xlat_set_match
  import xlat_pkg::*;
#(
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] tags [WAYS],
  input  logic [WAYS-1:0]  vld,
  input  logic [TAG_W-1:0] key,
  output logic [WAYS-1:0]  hit_vec,
  output logic             any,
  output logic [WAY_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld[w] && (tags[w] == key);
      if (hit_vec[w]) idx = WAY_W'(w);
    end
  end

  assign any = |hit_vec;

  // R4: no set ever holds the same tag twice
  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int SETS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_wr,
  output logic             lk_usr,
  output logic             lk_dty,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr,
  input  logic             fill_usr,
  input  logic             fill_dty,
  input  logic             flush
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [PFN_W-1:0] pfn_q  [SETS][WAYS];
  xlat_attr_t       attr_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAYS-1:0]  vld_d  [SETS];

  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_set = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign fl_set = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

  // lookup side
  logic [WAYS-1:0]  lk_vec;
  logic             lk_any;
  logic [WAY_W-1:0] lk_way;
  xlat_attr_t       lk_attr;

  xlat_set_match #(.TAG_W(TAG_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .tags(tag_q[lk_set]), .vld(vld_q[lk_set]),
    .key(lk_tag), .hit_vec(lk_vec), .any(lk_any), .idx(lk_way));

  assign lk_attr = attr_q[lk_set][lk_way];
  assign lk_hit  = lk_valid && lk_any && !(lk_write && !lk_attr.dty);
  assign lk_pfn  = lk_hit ? pfn_q[lk_set][lk_way] : '0;
  assign lk_wr   = lk_hit && lk_attr.wr;
  assign lk_usr  = lk_hit && lk_attr.usr;
  assign lk_dty  = lk_hit && lk_attr.dty;

  // fill side
  logic [WAYS-1:0]  fl_vec;
  logic             fl_any;
  logic [WAY_W-1:0] fl_hit_way, fl_free_way, fill_way;
  logic             fl_has_free, fill_go;
  logic [WAY_W-1:0] victim [SETS];

  xlat_set_match #(.TAG_W(TAG_W)) u_fl_match (
    .clk(clk), .rst_n(rst_n), .tags(tag_q[fl_set]), .vld(vld_q[fl_set]),
    .key(fl_tag), .hit_vec(fl_vec), .any(fl_any), .idx(fl_hit_way));

  always_comb begin
    fl_has_free = 1'b0;
    fl_free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[fl_set][w]) begin
        fl_has_free = 1'b1;
        fl_free_way = WAY_W'(w);
      end
    end
  end

  assign fill_go  = fill_en && !flush;
  assign fill_way = fl_any ? fl_hit_way : (fl_has_free ? fl_free_way : victim[fl_set]);

  // per-set replacement state
  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic fill_here, hit_here;
    assign fill_here = fill_go && (fl_set == IDX_W'(s));
    assign hit_here  = lk_hit && (lk_set == IDX_W'(s));

    xlat_plru u_plru (
      .clk(clk), .rst_n(rst_n), .clear(flush),
      .touch_en(fill_here || hit_here),
      .touch_way(fill_here ? fill_way : lk_way),
      .victim(victim[s]));
  end

  // next state of valid bits
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      vld_d[s] = flush ? '0 : vld_q[s];
    end
    if (fill_go) vld_d[fl_set][fill_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= vld_d[s];
    end
  end

  // data arrays: no reset, written only under the fill enable
  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[fl_set][fill_way]  <= fl_tag;
      pfn_q[fl_set][fill_way]  <= fill_pfn;
      attr_q[fl_set][fill_way] <= '{wr: fill_wr, usr: fill_usr, dty: fill_dty};
    end
  end

  // R3: a fill leaves a valid entry carrying its tag
  a_r3_fill_installs: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> (vld_q[$past(fl_set)][$past(fill_way)] &&
                 tag_q[$past(fl_set)][$past(fill_way)] == $past(fl_tag)));

  // R5: a reported write hit always carries a set dirty attribute
  a_r5_write_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write) |-> lk_dty);

  // R6: the cycle after a flush nothing can hit, fill or not
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  // R2: outputs stay quiet without a request
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && lk_pfn == '0));
endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  localparam int SETS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_write, fill_en, fill_wr, fill_usr, fill_dty, flush;
  logic [19:0] lk_vpn, fill_vpn, fill_pfn;
  logic        lk_hit, lk_wr, lk_usr, lk_dty;
  logic [19:0] lk_pfn;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  xlat_cache #(.VPN_W(20), .PFN_W(20), .SETS(SETS)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_wr(lk_wr), .lk_usr(lk_usr), .lk_dty(lk_dty),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_wr(fill_wr),
    .fill_usr(fill_usr), .fill_dty(fill_dty), .flush(flush));

  // vector: op(2) vpn(20) pfn(20) attr{wr,usr,dty}(3) hit(1)
  // op 0 = read lookup, 1 = write lookup, 2 = fill
  localparam int NV = 11;
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 20'h00010, 20'h00000, 3'b000, 1'b0},
    {2'd2, 20'h00010, 20'h00010, 3'b101, 1'b0},
    {2'd0, 20'h00010, 20'h00010, 3'b101, 1'b1},
    {2'd2, 20'h00000, 20'h000B8, 3'b110, 1'b0},
    {2'd1, 20'h00000, 20'h00000, 3'b000, 1'b0},
    {2'd0, 20'h00000, 20'h000B8, 3'b110, 1'b1},
    {2'd1, 20'h00010, 20'h00010, 3'b101, 1'b1},
    {2'd0, 20'h00004, 20'h00000, 3'b000, 1'b0},
    {2'd0, 20'h00011, 20'h00000, 3'b000, 1'b0},
    {2'd2, 20'h00011, 20'hABCDE, 3'b011, 1'b0},
    {2'd0, 20'h00011, 20'hABCDE, 3'b011, 1'b1}
  };

  task automatic check(input string req, input logic exp_hit, input logic [19:0] exp_pfn,
                       input logic [2:0] exp_attr);
    n_chk++;
    if (lk_hit !== exp_hit || lk_pfn !== exp_pfn || {lk_wr, lk_usr, lk_dty} !== exp_attr) begin
      n_err++;
      $display("FAIL %s vpn=%h: got hit=%b pfn=%h attr=%b, expected hit=%b pfn=%h attr=%b",
               req, lk_vpn, lk_hit, lk_pfn, {lk_wr, lk_usr, lk_dty}, exp_hit, exp_pfn, exp_attr);
    end
  endtask

  task automatic look(input string req, input logic [19:0] vpn, input logic wr,
                      input logic exp_hit, input logic [19:0] exp_pfn, input logic [2:0] exp_attr);
    @(negedge clk);
    fill_en = 1'b0; flush = 1'b0;
    lk_valid = 1'b1; lk_vpn = vpn; lk_write = wr;
    #1;
    check(req, exp_hit, exp_pfn, exp_attr);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [2:0] attr,
                      input logic fl);
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0;
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
    {fill_wr, fill_usr, fill_dty} = attr;
    flush = fl;
  endtask

  task automatic do_flush();
    @(negedge clk);
    lk_valid = 1'b0; fill_en = 1'b0; flush = 1'b1;
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: got no end, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 1'b0; lk_write = 1'b0; lk_vpn = '0;
    fill_en = 1'b0; fill_vpn = '0; fill_pfn = '0;
    fill_wr = 1'b0; fill_usr = 1'b0; fill_dty = 1'b0; flush = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look("R1", 20'h00010, 1'b0, 1'b0, 20'h0, 3'b000);

    // vector table: R2 read lookups, R5 write lookups, R3 fills
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][45:44] == 2'd2)
        fill(VEC[i][43:24], VEC[i][23:4], VEC[i][3:1], 1'b0);
      else
        look((VEC[i][45:44] == 2'd1) ? "R5" : "R2", VEC[i][43:24], VEC[i][44],
             VEC[i][0], VEC[i][0] ? VEC[i][23:4] : 20'h0, VEC[i][0] ? VEC[i][3:1] : 3'b000);
    end

    // R2: no request, no hit even for a cached page
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0; lk_vpn = 20'h00010; lk_write = 1'b0;
    #1;
    check("R2", 1'b0, 20'h0, 3'b000);

    // R6: flush empties everything
    do_flush();
    look("R6", 20'h00010, 1'b0, 1'b0, 20'h0, 3'b000);
    look("R6", 20'h00011, 1'b0, 1'b0, 20'h0, 3'b000);

    // R7/R8/R9: fill set 1 (vpn low bits 01) with four pages, one in set 2
    fill(20'h00001, 20'h10001, 3'b101, 1'b0);
    fill(20'h00005, 20'h10005, 3'b101, 1'b0);
    fill(20'h00009, 20'h10009, 3'b101, 1'b0);
    fill(20'h0000D, 20'h1000D, 3'b101, 1'b0);
    fill(20'h00002, 20'h10002, 3'b111, 1'b0);
    look("R8", 20'h00001, 1'b0, 1'b1, 20'h10001, 3'b101);
    // tree bits now b0=1 b2=0: victim is way 2 which holds 0x00009
    fill(20'h00011, 20'h10011, 3'b101, 1'b0);
    look("R8", 20'h00009, 1'b0, 1'b0, 20'h0, 3'b000);
    look("R7", 20'h00005, 1'b0, 1'b1, 20'h10005, 3'b101);
    look("R8", 20'h0000D, 1'b0, 1'b1, 20'h1000D, 3'b101);
    look("R3", 20'h00011, 1'b0, 1'b1, 20'h10011, 3'b101);
    look("R8", 20'h00001, 1'b0, 1'b1, 20'h10001, 3'b101);
    look("R9", 20'h00002, 1'b0, 1'b1, 20'h10002, 3'b111);

    // R4: refill of a cached page in a full set replaces it in place
    fill(20'h00005, 20'h2AAAA, 3'b110, 1'b0);
    look("R4", 20'h00005, 1'b0, 1'b1, 20'h2AAAA, 3'b110);
    look("R4", 20'h0000D, 1'b0, 1'b1, 20'h1000D, 3'b101);
    look("R4", 20'h00011, 1'b0, 1'b1, 20'h10011, 3'b101);
    look("R4", 20'h00001, 1'b0, 1'b1, 20'h10001, 3'b101);

    // R6: flush and fill together; the fill is lost
    fill(20'h00003, 20'h33333, 3'b111, 1'b1);
    look("R6", 20'h00003, 1'b0, 1'b0, 20'h0, 3'b000);
    look("R6", 20'h00001, 1'b0, 1'b0, 20'h0, 3'b000);
    look("R6", 20'h00002, 1'b0, 1'b0, 20'h0, 3'b000);

    // R1: asynchronous reset clears entries again
    fill(20'h00007, 20'h77777, 3'b111, 1'b0);
    look("R3", 20'h00007, 1'b1, 1'b1, 20'h77777, 3'b111);
    @(negedge clk);
    lk_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look("R1", 20'h00007, 1'b0, 1'b0, 20'h0, 3'b000);

    @(negedge clk);
    lk_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule